// File: doc/BRIEF.md
# DRAM Row-Time State Sequencer

This block runs the row-time phase of each external memory access. An access request latches the row address, a cycle-type code and the cycle configuration. The configuration is a 3-bit timing code, the device family (DRAM-style or SDRAM-style), refresh, write, pipelined write, and an SDRAM command. The sequencer then walks a fixed chain of row states. Optional states are inserted according to the latched timing code. The handshake inputs fault, ready and retry are honoured only in the states where they are meant to be sampled.

When row time is complete, a non-refresh access raises `colStart` to a separate column-time sequencer. It then waits for `colDone`, runs an optional drain state and goes back to idle. A refresh access instead passes through its own tail states, which show the processor activity code. An abort from outside restarts the row phase. A host bus request parks the block in a bus-release state in which every strobe output enable is withdrawn.

All strobe outputs are active-low registers that are decoded from the next state. Each strobe has its own output enable.

Top module: `row_time_seq`

## Requirements
- R1: After reset the block is idle. `rasN`, `weN`, `dbenN`, `rlN` and every `casN` bit are 1. `colStart`, `faultOut` and `dataDir` are 0, and all four output enables are 1.
- R2: `accReq` high in idle, with `hostReq` low, starts an access. On the next cycle the block is in the first row state. `addrOut` equals the `rowAddr` presented with the request, `statusOut` equals `cycType`, and every strobe is inactive (1), including `rlN`.
- R3: From the second row state until the access ends, `rlN` is 0 and `dataDir` equals the latched write flag.
- R4: `dbenN` is 0 exactly in the third row state, the three-cycle-column idle state and the row-strobe state, and is 1 elsewhere. On a DRAM-style write (not a refresh), `weN` is 0 from the third row state to the end of the access. On a DRAM-style refresh, all `casN` bits are 0 from the third row state through the last refresh state.
- R5: In the third row state, inputs are sampled with the priority `faultN` low, then `retryN` low, then `readyN` low. Fault ends the access in idle and pulses `faultOut` for exactly one cycle. Retry returns to the first row state. Ready low repeats the third row state.
- R6: The row path taken after the third row state is set by the timing code and device. The code 111 adds one extra state. The row-strobe state is visited for SDRAM-style devices and for codes 0xx and 11x. DRAM-style codes 100 and 101 go straight to the common fourth state, where `rasN` first goes low.
- R7: In the row-strobe state on SDRAM-style devices, `rasN` is 0. `weN` is 0 for commands 01 (precharge-all) and 10 (mode set). `casN` is 0 for command 10 and for refresh. The encoding 00 (and 11) means a plain read or write.
- R8: In the common fourth state, SDRAM-style devices drive `rasN`, `weN` and `casN` high. DRAM-style devices hold `rasN` low and `dbenN` high. Ready low holds this state, and retry low returns to the first row state.
- R9: While `spinReq` is high as the common fourth state would end, the block spins. The outputs do not change and `colStart` stays 0. `retryN` is still honoured during the spin. Column handoff follows once `spinReq` drops.
- R10: A refresh never raises `colStart`. Codes 11x add a first tail state, code 111 adds a second, and all refreshes end with a final tail state. During these tail states `statusOut` shows `actCode`. The block then returns to idle.
- R11: A non-refresh access holds `colStart` at 1 until `colDone` is seen. It then spends one drain cycle before idle if the device is SDRAM-style, or if it is a DRAM-style pipelined write with code 10x. The drain cycle drives `rasN` and `weN` low on SDRAM-style devices, and all `casN` bits low on pipelined writes.
- R12: `abortReq` in any state other than idle and bus release returns the block to the first row state on the next cycle, ahead of ready and retry. In idle it has no effect.
- R13: `hostReq` in idle takes priority over `accReq`. From the next cycle, all four output enables are 0 and stay 0 until `hostReq` falls. The enables return to 1 one cycle after `hostReq` falls, and no access has been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accReq | input | 1 | Start an access (sampled in idle) |
| rowAddr | input | ADDR_W | Row address of the access |
| cycType | input | STAT_W | Cycle-type status code |
| actCode | input | STAT_W | Processor activity code shown during refresh tail |
| timingCode | input | 3 | Cycles-per-column timing code |
| sdramDev | input | 1 | 1 = SDRAM-style device |
| refreshCyc | input | 1 | 1 = refresh cycle |
| writeCyc | input | 1 | 1 = write transfer |
| pipeWrite | input | 1 | 1 = pipelined single-cycle-per-column write |
| sdramCmd | input | 2 | 00/11 read-write, 01 precharge-all, 10 mode set |
| faultN | input | 1 | Fault, active low |
| readyN | input | 1 | Ready, low = wait |
| retryN | input | 1 | Retry, active low |
| abortReq | input | 1 | Abort current cycle |
| hostReq | input | 1 | Host bus request |
| spinReq | input | 1 | Column pipeline not yet loaded |
| colDone | input | 1 | Column sequencer finished |
| addrOut | output | ADDR_W | Latched row address |
| statusOut | output | STAT_W | Status code |
| rasN | output | 1 | Row strobe |
| casN | output | CAS_W | Column strobes |
| weN | output | 1 | Write strobe |
| dbenN | output | 1 | Data buffer enable |
| rlN | output | 1 | Row latch |
| dataDir | output | 1 | Data direction, 1 = outbound |
| colStart | output | 1 | Column-time start request |
| faultOut | output | 1 | One-cycle fault indication |
| rasOe | output | 1 | Output enable of rasN |
| casOe | output | 1 | Output enable of casN |
| weOe | output | 1 | Output enable of weN |
| dbenOe | output | 1 | Output enable of dbenN |

## Verification
All outputs are registered and decoded from the next state. An input change applied before a rising edge therefore appears on the outputs just after that same edge: one cycle after the stimulus, and in the same cycle the state changes. The bench drives inputs on the falling edge and compares on the next falling edge. For each access it builds, from the requirements, the expected sequence of states one entry per cycle, and compares every strobe in every cycle against that sequence. Handshake inputs for the fault, retry, ready, spin, abort and host cases are set on the falling edge at which the targeted state is observed. Their effect is checked on the following falling edge.

// File: rtl/row_time_pkg.sv
package row_time_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_R1, ST_R2, ST_R3, ST_R4, ST_R5, ST_R6, ST_SPIN,
    ST_RF1, ST_RF2, ST_RF3, ST_COLW, ST_DRN, ST_HIZ
  } rowState_e;

  localparam logic [1:0] CMD_RW     = 2'b00;
  localparam logic [1:0] CMD_PREALL = 2'b01;
  localparam logic [1:0] CMD_MODE   = 2'b10;

  typedef struct packed {
    logic [2:0] code;
    logic       sdram;
    logic       refresh;
    logic       write;
    logic       pipeWr;
    logic [1:0] cmd;
  } cycCfg_t;

  typedef struct packed {
    rowState_e nxt;
    logic      loadCfg;
    logic      faultHit;
  } rowStrobes_t;

endpackage

// File: rtl/row_time_ctrl.sv
module row_time_ctrl
  import row_time_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accReq,
  input  logic        hostReq,
  input  logic        abortReq,
  input  logic        spinReq,
  input  logic        colDone,
  input  logic        faultN,
  input  logic        readyN,
  input  logic        retryN,
  input  cycCfg_t     cfgQ,
  input  cycCfg_t     cfgIn,
  output rowStrobes_t strb,
  output rowState_e   curState
);

  rowState_e stateQ, stateD;
  cycCfg_t   cfgUse;
  logic      needR5, needDrain, hitFault;

  // during the accept edge the fresh configuration is the one that counts
  assign cfgUse    = (stateQ == ST_IDLE) ? cfgIn : cfgQ;
  assign needR5    = cfgUse.sdram || !cfgUse.code[2] || (cfgUse.code[2:1] == 2'b11);
  assign needDrain = !cfgUse.refresh &&
                     (cfgUse.sdram ||
                      (cfgUse.pipeWr && cfgUse.write && cfgUse.code[2:1] == 2'b10));

  function automatic rowState_e afterRow(input cycCfg_t c, input logic spin);
    if (spin)                     return ST_SPIN;
    else if (!c.refresh)          return ST_COLW;
    else if (c.code[2:1] == 2'b11) return ST_RF1;
    else                          return ST_RF3;
  endfunction

  always_comb begin
    stateD   = stateQ;
    hitFault = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (hostReq)     stateD = ST_HIZ;
        else if (accReq) stateD = ST_R1;
      end
      ST_HIZ:  stateD = hostReq ? ST_HIZ : ST_IDLE;
      ST_R1:   stateD = ST_R2;
      ST_R2:   stateD = ST_R3;
      ST_R3: begin
        if (!faultN) begin
          stateD   = ST_IDLE;
          hitFault = 1'b1;
        end
        else if (!retryN)            stateD = ST_R1;
        else if (!readyN)            stateD = ST_R3;
        else if (cfgUse.code == 3'b111) stateD = ST_R4;
        else if (needR5)             stateD = ST_R5;
        else                         stateD = ST_R6;
      end
      ST_R4:   stateD = !retryN ? ST_R1 : ST_R5;
      ST_R5:   stateD = ST_R6;
      ST_R6: begin
        if (!retryN)      stateD = ST_R1;
        else if (!readyN) stateD = ST_R6;
        else              stateD = afterRow(cfgUse, spinReq);
      end
      ST_SPIN: stateD = !retryN ? ST_R1 : afterRow(cfgUse, spinReq);
      ST_RF1:  stateD = !retryN ? ST_R1 :
                        (cfgUse.code == 3'b111) ? ST_RF2 : ST_RF3;
      ST_RF2:  stateD = !retryN ? ST_R1 : ST_RF3;
      ST_RF3:  stateD = !retryN ? ST_R1 : ST_IDLE;
      ST_COLW: begin
        if (colDone) stateD = needDrain ? ST_DRN : ST_IDLE;
      end
      ST_DRN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
    // abort overrides every wait, retry and fault decision inside an access
    if (abortReq && stateQ != ST_IDLE && stateQ != ST_HIZ) begin
      stateD   = ST_R1;
      hitFault = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strb.nxt      = stateD;
  assign strb.loadCfg  = (stateQ == ST_IDLE) && (stateD == ST_R1);
  assign strb.faultHit = hitFault;
  assign curState      = stateQ;

endmodule

// File: rtl/row_time_dp.sv
module row_time_dp
  import row_time_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 6,
  parameter int CAS_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rowStrobes_t       strb,
  input  cycCfg_t           cfgIn,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [STAT_W-1:0] cycType,
  input  logic [STAT_W-1:0] actCode,
  output cycCfg_t           cfgQ,
  output logic [ADDR_W-1:0] addrOut,
  output logic [STAT_W-1:0] statusOut,
  output logic              rasN,
  output logic [CAS_W-1:0]  casN,
  output logic              weN,
  output logic              dbenN,
  output logic              rlN,
  output logic              dataDir,
  output logic              colStart,
  output logic              faultOut,
  output logic [3:0]        oeVec
);

  localparam int OE_N = 4;

  cycCfg_t           cfgN;
  logic [STAT_W-1:0] typeQ, typeN;
  rowState_e         n;
  logic inAcc, fromR3, rasLow, casLow, weLow, dbenLow, relBus;

  assign n     = strb.nxt;
  assign cfgN  = strb.loadCfg ? cfgIn : cfgQ;
  assign typeN = strb.loadCfg ? cycType : typeQ;

  always_comb begin
    inAcc   = !(n inside {ST_IDLE, ST_R1, ST_HIZ});
    fromR3  = inAcc && (n != ST_R2);
    dbenLow = n inside {ST_R3, ST_R4, ST_R5};
    relBus  = (n == ST_HIZ);
    if (cfgN.sdram) begin
      rasLow = (n == ST_R5) || (n == ST_DRN);
      casLow = (n == ST_R5) && (cfgN.refresh || cfgN.cmd == CMD_MODE);
      weLow  = ((n == ST_R5) && (cfgN.cmd == CMD_PREALL || cfgN.cmd == CMD_MODE)) ||
               (n == ST_DRN);
    end else begin
      rasLow = n inside {ST_R5, ST_R6, ST_SPIN, ST_RF1, ST_RF2, ST_RF3, ST_COLW, ST_DRN};
      casLow = cfgN.refresh
             ? (n inside {ST_R3, ST_R4, ST_R5, ST_R6, ST_SPIN, ST_RF1, ST_RF2, ST_RF3})
             : (n == ST_DRN);
      weLow  = cfgN.write && !cfgN.refresh && fromR3;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      typeQ   <= '0;
      addrOut <= '0;
    end else if (strb.loadCfg) begin
      cfgQ    <= cfgIn;
      typeQ   <= cycType;
      addrOut <= rowAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN      <= 1'b1;
      casN      <= '1;
      weN       <= 1'b1;
      dbenN     <= 1'b1;
      rlN       <= 1'b1;
      dataDir   <= 1'b0;
      colStart  <= 1'b0;
      faultOut  <= 1'b0;
      statusOut <= '0;
    end else begin
      rasN     <= !rasLow;
      casN     <= {CAS_W{!casLow}};
      weN      <= !weLow;
      dbenN    <= !dbenLow;
      rlN      <= !inAcc;
      dataDir  <= inAcc && cfgN.write;
      colStart <= (n == ST_COLW);
      faultOut <= strb.faultHit;
      if (n == ST_RF1 || n == ST_RF3) statusOut <= actCode;
      else if (n != ST_RF2)           statusOut <= typeN;
    end
  end

  // one enable register per tri-stated strobe
  for (genvar g = 0; g < OE_N; g++) begin : g_oe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) oeVec[g] <= 1'b1;
      else       oeVec[g] <= !relBus;
    end
  end

endmodule

// File: rtl/row_time_seq.sv
module row_time_seq
  import row_time_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 6,
  parameter int CAS_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accReq,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic [STAT_W-1:0] cycType,
  input  logic [STAT_W-1:0] actCode,
  input  logic [2:0]        timingCode,
  input  logic              sdramDev,
  input  logic              refreshCyc,
  input  logic              writeCyc,
  input  logic              pipeWrite,
  input  logic [1:0]        sdramCmd,
  input  logic              faultN,
  input  logic              readyN,
  input  logic              retryN,
  input  logic              abortReq,
  input  logic              hostReq,
  input  logic              spinReq,
  input  logic              colDone,
  output logic [ADDR_W-1:0] addrOut,
  output logic [STAT_W-1:0] statusOut,
  output logic              rasN,
  output logic [CAS_W-1:0]  casN,
  output logic              weN,
  output logic              dbenN,
  output logic              rlN,
  output logic              dataDir,
  output logic              colStart,
  output logic              faultOut,
  output logic              rasOe,
  output logic              casOe,
  output logic              weOe,
  output logic              dbenOe
);

  cycCfg_t     cfgIn, cfgQ;
  rowStrobes_t strb;
  rowState_e   curState;
  logic [3:0]  oeVec;

  assign cfgIn = '{code: timingCode, sdram: sdramDev, refresh: refreshCyc,
                   write: writeCyc, pipeWr: pipeWrite, cmd: sdramCmd};

  row_time_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accReq(accReq), .hostReq(hostReq),
    .abortReq(abortReq), .spinReq(spinReq), .colDone(colDone),
    .faultN(faultN), .readyN(readyN), .retryN(retryN),
    .cfgQ(cfgQ), .cfgIn(cfgIn), .strb(strb), .curState(curState)
  );

  row_time_dp #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .CAS_W(CAS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIn(cfgIn),
    .rowAddr(rowAddr), .cycType(cycType), .actCode(actCode),
    .cfgQ(cfgQ), .addrOut(addrOut), .statusOut(statusOut),
    .rasN(rasN), .casN(casN), .weN(weN), .dbenN(dbenN), .rlN(rlN),
    .dataDir(dataDir), .colStart(colStart), .faultOut(faultOut),
    .oeVec(oeVec)
  );

  assign rasOe  = oeVec[0];
  assign casOe  = oeVec[1];
  assign weOe   = oeVec[2];
  assign dbenOe = oeVec[3];

endmodule

// File: rtl/row_time_chk.sv
module row_time_chk
  import row_time_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input rowState_e curState,
  input cycCfg_t   cfgQ,
  input logic      abortReq,
  input logic      hostReq,
  input logic      faultN,
  input logic      readyN,
  input logic      retryN,
  input logic      faultOut,
  input logic      colStart,
  input logic      rlN,
  input logic      dbenN,
  input logic      rasOe,
  input logic      casOe
);

  p_dben_r3_r4: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_R3 |-> !dbenN);

  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_R3 && faultN && retryN && !readyN && !abortReq) |=> curState == ST_R3);

  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |=> !faultOut);

  p_extra_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_R4 |-> cfgQ.code == 3'b111);

  p_no_refresh_handoff_r10: assert property (@(posedge clk) disable iff (!rstN)
    colStart |-> !cfgQ.refresh);

  p_colstart_latch_r11: assert property (@(posedge clk) disable iff (!rstN)
    colStart |-> !rlN);

  p_abort_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && curState != ST_IDLE && curState != ST_HIZ) |=> curState == ST_R1);

  p_release_cause_r13: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasOe) |-> $past(hostReq));

  p_release_exit_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!rasOe && !hostReq) |=> (rasOe && casOe));

endmodule

bind row_time_seq row_time_chk chk_i (
  .clk(clk), .rstN(rstN), .curState(curState), .cfgQ(cfgQ),
  .abortReq(abortReq), .hostReq(hostReq), .faultN(faultN),
  .readyN(readyN), .retryN(retryN), .faultOut(faultOut),
  .colStart(colStart), .rlN(rlN), .dbenN(dbenN),
  .rasOe(rasOe), .casOe(casOe)
);

// File: tb/row_time_seq_tb_top.sv
`timescale 1ns/1ps
module row_time_seq_tb_top;

  localparam int AW = 16, SW = 6, CW = 4;
  // bench-side state numbering
  localparam int B_IDLE = 0, B_R1 = 1, B_R2 = 2, B_R3 = 3, B_R4 = 4, B_R5 = 5,
                 B_R6 = 6, B_F1 = 7, B_F2 = 8, B_F3 = 9, B_CW = 10, B_DR = 11;

  logic clk = 0, rstN = 0;
  logic accReq = 0, sdramDev = 0, refreshCyc = 0, writeCyc = 0, pipeWrite = 0;
  logic [AW-1:0] rowAddr = '0;
  logic [SW-1:0] cycType = '0, actCode = '0;
  logic [2:0] timingCode = '0;
  logic [1:0] sdramCmd = '0;
  logic faultN = 1, readyN = 1, retryN = 1, abortReq = 0, hostReq = 0, spinReq = 0, colDone = 0;
  logic [AW-1:0] addrOut;
  logic [SW-1:0] statusOut;
  logic rasN, weN, dbenN, rlN, dataDir, colStart, faultOut, rasOe, casOe, weOe, dbenOe;
  logic [CW-1:0] casN;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  row_time_seq #(.ADDR_W(AW), .STAT_W(SW), .CAS_W(CW)) dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // packed {rasN, casAll, weN, dbenN, rlN, dataDir, colStart}
  function automatic logic [6:0] expOut(int s, bit sd, bit rf, bit wr, logic [1:0] cmd);
    bit ras, cas, we, dben, rl, dir, cs, acc;
    acc  = !(s == B_IDLE || s == B_R1);
    rl   = acc;
    dir  = acc && wr;
    dben = (s == B_R3 || s == B_R4 || s == B_R5);
    cs   = (s == B_CW);
    if (sd) begin
      ras = (s == B_R5 || s == B_DR);
      cas = (s == B_R5) && (rf || cmd == 2'b10);
      we  = (s == B_R5 && (cmd == 2'b01 || cmd == 2'b10)) || s == B_DR;
    end else begin
      ras = (s >= B_R5);
      cas = rf ? (s >= B_R3 && s <= B_F3) : (s == B_DR);
      we  = wr && !rf && acc && s != B_R2;
    end
    return {!ras, !cas, !we, !dben, !rl, dir, cs};
  endfunction

  function automatic logic [6:0] dutOut();
    return {rasN, casN[0], weN, dbenN, rlN, dataDir, colStart};
  endfunction

  task automatic startAcc(input logic [2:0] code, input bit sd, input bit rf, input bit wr,
                          input bit pw, input logic [1:0] cmd);
    @(negedge clk);
    timingCode = code; sdramDev = sd; refreshCyc = rf; writeCyc = wr;
    pipeWrite = pw; sdramCmd = cmd;
    cycType = {code, sd, rf, wr};
    actCode = ~cycType;
    rowAddr = {code, cmd, sd, rf, wr, pw, 8'h5A};
    accReq = 1;
  endtask

  task automatic runAccess(input logic [2:0] code, input bit sd, input bit rf, input bit wr,
                           input bit pw, input logic [1:0] cmd);
    int path[16];
    int len = 0;
    path[len++] = B_R1; path[len++] = B_R2; path[len++] = B_R3;
    if (code == 3'b111) path[len++] = B_R4;
    if (sd || !code[2] || code[2:1] == 2'b11) path[len++] = B_R5;
    path[len++] = B_R6;
    if (rf) begin
      if (code[2:1] == 2'b11) path[len++] = B_F1;
      if (code == 3'b111) path[len++] = B_F2;
      path[len++] = B_F3;
    end else begin
      path[len++] = B_CW; path[len++] = B_CW;
      if (sd || (pw && wr && code[2:1] == 2'b10)) path[len++] = B_DR;
    end
    startAcc(code, sd, rf, wr, pw, cmd);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      accReq = 0;
      // R3 R4 R6 R7 R8 R10 R11: strobes per state along the expected path
      chk(dutOut() == expOut(path[i], sd, rf, wr, cmd) && casN == {CW{casN[0]}},
          $sformatf("R6/R7/R8/R10/R11 code=%0d sd=%0d rf=%0d wr=%0d pw=%0d cmd=%0d step=%0d",
                    code, sd, rf, wr, pw, cmd, i),
          {casN, dutOut()}, {{CW{expOut(path[i], sd, rf, wr, cmd)[5]}},
                              expOut(path[i], sd, rf, wr, cmd)});
      if (path[i] == B_R1) begin
        chk(statusOut == cycType && addrOut == rowAddr, "R2 status/address", statusOut, cycType);
      end
      if (path[i] == B_F3)
        chk(statusOut == actCode, "R10 activity code", statusOut, actCode);
      colDone = (path[i] == B_CW && i > 0 && path[i-1] == B_CW);
    end
    @(negedge clk);
    colDone = 0;
    chk(dutOut() == expOut(B_IDLE, sd, rf, wr, cmd), "R11 back to idle", dutOut(),
        expOut(B_IDLE, sd, rf, wr, cmd));
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    chk({rasN, casN, weN, dbenN, rlN} == '1 && !colStart && !faultOut && !dataDir &&
        {rasOe, casOe, weOe, dbenOe} == 4'hF, "R1 reset state",
        {rasN, casN, weN, dbenN, rlN}, '1);
    rstN = 1;
    @(negedge clk);
    chk(rlN && !colStart, "R1 idle after reset", rlN, 1);

    // sweep of the configuration space
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        for (int r = 0; r < 2; r++)
          for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
              for (int m = 0; m < (s ? 3 : 1); m++)
                runAccess(c[2:0], s[0], r[0], w[0], p[0], m[1:0]);

    // R5: fault wins over retry in the third row state, one-cycle pulse
    startAcc(3'b100, 0, 0, 0, 0, 2'b00);
    repeat (3) begin @(negedge clk); accReq = 0; end
    faultN = 0; retryN = 0;
    @(negedge clk);
    chk(faultOut && rlN, "R5 fault ends access", {faultOut, rlN}, 2'b11);
    faultN = 1; retryN = 1;
    @(negedge clk);
    chk(!faultOut && rlN, "R5 fault pulse single cycle", faultOut, 0);

    // R5: retry over ready restarts row time
    startAcc(3'b100, 0, 0, 0, 0, 2'b00);
    repeat (3) begin @(negedge clk); accReq = 0; end
    retryN = 0; readyN = 0;
    @(negedge clk);
    chk(rlN && dbenN, "R5 retry back to first row state", {rlN, dbenN}, 2'b11);
    retryN = 1; readyN = 1;
    @(negedge clk);
    chk(!rlN && dbenN, "R5 retry second row state", {rlN, dbenN}, 2'b01);
    @(negedge clk);
    chk(!dbenN, "R5 retry third row state", dbenN, 0);
    // R5: ready low repeats the third row state
    readyN = 0;
    repeat (2) begin
      @(negedge clk);
      chk(!dbenN && rasN, "R5 ready wait holds state", {dbenN, rasN}, 2'b01);
    end
    readyN = 1;
    @(negedge clk);
    chk(dbenN && !rasN, "R8 DRAM fourth state", {dbenN, rasN}, 2'b10);
    // R9: spin while the column pipeline loads
    spinReq = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!colStart && !rasN && dbenN && !rlN, "R9 spin holds outputs", colStart, 0);
    end
    spinReq = 0;
    @(negedge clk);
    chk(colStart, "R9 handoff after spin", colStart, 1);
    colDone = 1;
    @(negedge clk);
    colDone = 0;
    chk(!colStart && rlN, "R11 idle after colDone", colStart, 0);

    // R9: retry honoured during spin
    startAcc(3'b101, 0, 0, 0, 0, 2'b00);
    repeat (4) begin @(negedge clk); accReq = 0; end
    spinReq = 1;
    @(negedge clk);
    retryN = 0;
    @(negedge clk);
    chk(rlN && rasN, "R9 retry during spin", {rlN, rasN}, 2'b11);
    retryN = 1; spinReq = 0;
    repeat (4) @(negedge clk);
    chk(colStart, "R9 handoff after retried spin", colStart, 1);
    colDone = 1;
    @(negedge clk);
    colDone = 0;

    // R12: abort beats ready and retry, also during column handoff
    startAcc(3'b100, 0, 0, 0, 0, 2'b00);
    repeat (3) begin @(negedge clk); accReq = 0; end
    readyN = 0; retryN = 0; abortReq = 1;
    @(negedge clk);
    chk(rlN && dbenN, "R12 abort to first row state", {rlN, dbenN}, 2'b11);
    readyN = 1; retryN = 1; abortReq = 0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk(colStart, "R12 resumed access reaches handoff", colStart, 1);
    abortReq = 1;
    @(negedge clk);
    abortReq = 0;
    chk(!colStart && rlN, "R12 abort during handoff", {colStart, rlN}, 2'b01);
    repeat (4) @(negedge clk);
    colDone = 1;
    @(negedge clk);
    colDone = 0;
    chk(!colStart && rlN, "R12 access completes", colStart, 0);
    abortReq = 1;
    repeat (2) begin
      @(negedge clk);
      chk(rlN && !colStart && rasOe, "R12 abort ignored in idle", rlN, 1);
    end
    abortReq = 0;

    // R13: host request beats access request
    @(negedge clk);
    hostReq = 1; accReq = 1;
    @(negedge clk);
    accReq = 0;
    chk({rasOe, casOe, weOe, dbenOe} == 4'h0 && rlN, "R13 bus released",
        {rasOe, casOe, weOe, dbenOe}, 0);
    repeat (2) begin
      @(negedge clk);
      chk({rasOe, casOe, weOe, dbenOe} == 4'h0, "R13 bus stays released",
          {rasOe, casOe, weOe, dbenOe}, 0);
    end
    hostReq = 0;
    @(negedge clk);
    chk({rasOe, casOe, weOe, dbenOe} == 4'hF && rlN, "R13 bus reclaimed",
        {rasOe, casOe, weOe, dbenOe}, 4'hF);
    @(negedge clk);
    chk(rlN && !colStart, "R13 no access started", rlN, 1);

    done = 1;
    finishRun();
  end

endmodule